// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits on a game cartridge between an 8-bit CPU, a picture processor and two ROMs. CPU writes into the upper half of the CPU address space are decoded into a small set of bank registers. These registers do not hold data for reading. They set which ROM bank each address window sees. The block combines the CPU read address with a program bank to form a wider program-ROM address. It combines the picture-processor address with a pattern bank to form a wider pattern-ROM address. It also drives the address line that selects which half of the console's nametable RAM is used, and so sets the mirroring.

The CPU has two switchable 8 KB program windows and a fixed 16 KB window at the top, which always holds the last two banks of program ROM. The pattern space is split into eight 1 KB windows. Each window has an 8-bit register that is loaded 4 bits at a time. The bank used for a window is that register shifted right by one. Only four data lines reach the block, so every register write carries a nibble. The program bank width is a parameter. Both address outputs are plain concatenations of a bank number and the low address bits.

Top module: `cart_mapper`

## Requirements
- R1: A qualified write to CPU $8000–$8003 loads the 4-bit data as the program bank for CPU $8000–$9FFF (cpu_addr[14:13]=00). prg_addr is {bank, cpu_addr[12:0]}.
- R2: A qualified write to CPU $A000–$A003 loads the 4-bit data as the program bank for CPU $A000–$BFFF (cpu_addr[14:13]=01).
- R3: A qualified write to $9000–$9003 sets the mirroring mode from data[1:0]. Mode 0 gives ciram_a10 = ppu_addr[10]. Mode 1 gives ppu_addr[11]. Mode 2 gives constant 0. Mode 3 gives constant 1.
- R4: Pattern registers 0/1 are at $B000, 2/3 at $C000, 4/5 at $D000 and 6/7 at $E000. Address bit 0 picks the odd register of the pair. Address bit 1 picks the nibble: 0 writes bits 3:0 and 1 writes bits 7:4. The other nibble keeps its value.
- R5: ppu_addr[12:10] selects one pattern register. chr_addr is {register[7:1], ppu_addr[9:0]}.
- R6: CPU $C000–$DFFF (cpu_addr[14:13]=10) always uses the second-to-last program bank. CPU $E000–$FFFF (cpu_addr[14:13]=11) always uses the last program bank. No write changes either of them.
- R7: While rst_n is low, the following hold: all pattern registers are zero, both switchable program banks are zero, and the mirroring mode is 0.
- R8: A write has no effect if any of these is true: cpu_we is low, cpu_rw is high, cpu_addr[15] is 0, or cpu_addr[11:2] is nonzero.
- R9: A qualified write takes effect at the rising clock edge where it is presented. The address outputs follow their input addresses with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 4 | CPU data bits 3:0 |
| cpu_we | input | 1 | CPU write strobe |
| cpu_rw | input | 1 | CPU read/write, 0 = write |
| ppu_addr | input | 13 | Picture-processor address bits 12:0 |
| prg_addr | output | PRG_BANK_W+13 | Program ROM address |
| chr_addr | output | 17 | Pattern ROM address |
| ciram_a10 | output | 1 | Nametable RAM half select |

## Verification
A faulty register holds its wrong value until the next write to it. At the ports, the only sign is a wrong bank on reads from one specific window. The fault stays hidden until the matching address range is read. For pattern registers, a bad bit 0 never shows at all, because that bit is dropped from the bank number. The bench varies both read addresses on every cycle and compares all three outputs against a model on every cycle. A register fault therefore shows within the few cycles it takes the random read addresses to land in the affected window.

// File: rtl/cart_mapper.sv
module cart_mapper #(
  parameter int PRG_BANK_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             cpu_addr,
  input  logic [3:0]              cpu_data,
  input  logic                    cpu_we,
  input  logic                    cpu_rw,
  input  logic [12:0]             ppu_addr,
  output logic [PRG_BANK_W+12:0]  prg_addr,
  output logic [16:0]             chr_addr,
  output logic                    ciram_a10
);
  localparam int NCHR = 8;
  localparam logic [PRG_BANK_W-1:0] BANK_LAST = '1;
  localparam logic [PRG_BANK_W-1:0] BANK_PREV = BANK_LAST - 1'b1;

  logic [PRG_BANK_W-1:0] prg_lo_q, prg_hi_q;
  logic [1:0]            mir_q;
  logic [7:0]            chr_q [NCHR];

  wire       wr_ok   = cpu_we & ~cpu_rw & cpu_addr[15] & (cpu_addr[11:2] == 10'd0);
  wire [3:0] page    = cpu_addr[15:12];
  wire       wr_plo  = wr_ok & (page == 4'h8);
  wire       wr_mir  = wr_ok & (page == 4'h9);
  wire       wr_phi  = wr_ok & (page == 4'hA);
  wire       wr_chr  = wr_ok & (page >= 4'hB) & (page <= 4'hE);
  wire [3:0] pair    = page - 4'hB;
  wire [2:0] chr_sel = {pair[1:0], cpu_addr[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_lo_q <= '0;
      prg_hi_q <= '0;
      mir_q    <= 2'd0;
    end else begin
      if (wr_plo) prg_lo_q <= PRG_BANK_W'(cpu_data);
      if (wr_phi) prg_hi_q <= PRG_BANK_W'(cpu_data);
      if (wr_mir) mir_q    <= cpu_data[1:0];
    end
  end

  for (genvar i = 0; i < NCHR; i++) begin : g_chr
    wire hit = wr_chr & (chr_sel == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chr_q[i] <= 8'd0;
      else if (hit) begin
        if (cpu_addr[1]) chr_q[i][7:4] <= cpu_data;
        else             chr_q[i][3:0] <= cpu_data;
      end
    end

    a_r4_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !cpu_addr[1]) |=> (chr_q[i][7:4] == $past(chr_q[i][7:4])));
    a_r4_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cpu_addr[1]) |=> (chr_q[i][3:0] == $past(chr_q[i][3:0])));
  end

  logic [PRG_BANK_W-1:0] prg_bank;
  always_comb begin
    case (cpu_addr[14:13])
      2'b00:   prg_bank = prg_lo_q;
      2'b01:   prg_bank = prg_hi_q;
      2'b10:   prg_bank = BANK_PREV;
      default: prg_bank = BANK_LAST;
    endcase
  end
  assign prg_addr = {prg_bank, cpu_addr[12:0]};

  wire [7:0] chr_cur = chr_q[ppu_addr[12:10]];
  assign chr_addr = {chr_cur[7:1], ppu_addr[9:0]};

  always_comb begin
    case (mir_q)
      2'd0:    ciram_a10 = ppu_addr[10];
      2'd1:    ciram_a10 = ppu_addr[11];
      2'd2:    ciram_a10 = 1'b0;
      default: ciram_a10 = 1'b1;
    endcase
  end

  a_r1_low_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_plo |=> (prg_lo_q == PRG_BANK_W'($past(cpu_data))));
  a_r8_ignore_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we || cpu_rw || !cpu_addr[15]) |=>
      ($stable(prg_lo_q) && $stable(prg_hi_q) && $stable(mir_q)));
  a_r6_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'b11) |-> (prg_addr[PRG_BANK_W+12:13] == BANK_LAST));
  a_r3_single_screen: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_q[1]) |-> (ciram_a10 == mir_q[0]));
endmodule

// File: tb/cart_mapper_test.sv
`timescale 1ns/100ps
module cart_mapper_test;
  localparam int PB = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [3:0]  cpu_data = '0;
  logic cpu_we = 1'b0, cpu_rw = 1'b1;
  logic [12:0] ppu_addr = '0;
  logic [PB+12:0] prg_addr;
  logic [16:0] chr_addr;
  logic ciram_a10;

  int checks = 0, failures = 0;
  int m_plo = 0, m_phi = 0, m_mir = 0;
  int m_chr [8];
  bit done = 0;

  cart_mapper #(.PRG_BANK_W(PB)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_we(cpu_we), .cpu_rw(cpu_rw), .ppu_addr(ppu_addr),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .ciram_a10(ciram_a10));

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_plo = 0; m_phi = 0; m_mir = 0;
      for (int k = 0; k < 8; k++) m_chr[k] = 0;
    end else if (cpu_we && !cpu_rw && cpu_addr >= 16'h8000 && (cpu_addr & 16'h0FFC) == 0) begin
      int pg, idx;
      pg = cpu_addr >> 12;
      if (pg == 8) m_plo = cpu_data;
      else if (pg == 10) m_phi = cpu_data;
      else if (pg == 9) m_mir = cpu_data % 4;
      else if (pg >= 11 && pg <= 14) begin
        idx = (pg - 11) * 2 + (cpu_addr % 2);
        if ((cpu_addr / 2) % 2 == 1) m_chr[idx] = (m_chr[idx] % 16) + cpu_data * 16;
        else m_chr[idx] = (m_chr[idx] / 16) * 16 + cpu_data;
      end
    end
  end

  task automatic compare(input string tag);
    int win, bank, exp_prg, exp_chr, exp_a10;
    win = (cpu_addr / 8192) % 4;
    case (win)
      0: bank = m_plo;
      1: bank = m_phi;
      2: bank = (1 << PB) - 2;
      default: bank = (1 << PB) - 1;
    endcase
    exp_prg = bank * 8192 + (cpu_addr % 8192);
    exp_chr = (m_chr[ppu_addr / 1024] / 2) * 1024 + (ppu_addr % 1024);
    case (m_mir)
      0: exp_a10 = (ppu_addr / 1024) % 2;
      1: exp_a10 = (ppu_addr / 2048) % 2;
      2: exp_a10 = 0;
      default: exp_a10 = 1;
    endcase
    checks += 3;
    if (int'(prg_addr) != exp_prg) begin
      failures++;
      $display("FAIL %s R1/R2/R6 prg_addr actual=%h expected=%h", tag, prg_addr, exp_prg);
    end
    if (int'(chr_addr) != exp_chr) begin
      failures++;
      $display("FAIL %s R4/R5 chr_addr actual=%h expected=%h", tag, chr_addr, exp_chr);
    end
    if (int'(ciram_a10) != exp_a10) begin
      failures++;
      $display("FAIL %s R3 ciram_a10 actual=%0d expected=%0d", tag, ciram_a10, exp_a10);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [3:0] d, input logic we,
                      input logic rw, input logic [12:0] p, input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = we; cpu_rw = rw; ppu_addr = p;
    #1;
    compare(tag);
  endtask

  function automatic logic [15:0] pick_addr(int r);
    logic [15:0] regs [13] = '{16'h8000, 16'h8003, 16'h9001, 16'hA002, 16'hB000,
      16'hB003, 16'hC001, 16'hC002, 16'hD000, 16'hD003, 16'hE001, 16'hE002, 16'hF000};
    if (r % 4 == 0) return 16'($urandom);
    if (r % 4 == 1) return regs[$urandom % 13] | 16'h0004;
    return regs[$urandom % 13] | 16'($urandom % 4);
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) step(16'(i * 16'h2000), 4'hF, 1'b1, 1'b0, 13'(i * 1024), "R7 reset");
    rst_n = 1'b1;
    // R1 R2 R9: direct loads, read back in the following cycle
    step(16'h8002, 4'h5, 1'b1, 1'b0, 13'h0, "R1 load");
    step(16'h8123, 4'h0, 1'b0, 1'b1, 13'h0, "R1 read");
    step(16'hA001, 4'hA, 1'b1, 1'b0, 13'h0, "R2 load");
    step(16'hB456, 4'h0, 1'b0, 1'b1, 13'h0, "R2 read");
    // R6: try to disturb the fixed windows
    step(16'hF000, 4'h3, 1'b1, 1'b0, 13'h0, "R6 write");
    step(16'hC010, 4'h0, 1'b0, 1'b1, 13'h0, "R6 read lo");
    step(16'hFFFF, 4'h0, 1'b0, 1'b1, 13'h0, "R6 read hi");
    // R4 R5: nibbles of register 3 then register 6
    step(16'hC001, 4'h7, 1'b1, 1'b0, 13'h0C00, "R4 low nibble");
    step(16'hC003, 4'hB, 1'b1, 1'b0, 13'h0C00, "R4 high nibble");
    step(16'h0000, 4'h0, 1'b0, 1'b1, 13'h0C55, "R5 read");
    step(16'hE002, 4'h9, 1'b1, 1'b0, 13'h1800, "R4 reg6 high");
    step(16'h0000, 4'h0, 1'b0, 1'b1, 13'h1BFF, "R5 reg6");
    // R3: all four mirroring modes
    for (int m = 0; m < 4; m++) begin
      step(16'h9000 | 16'(m), 4'(m), 1'b1, 1'b0, 13'h0, "R3 set");
      for (int q = 0; q < 4; q++) step(16'h0, 4'h0, 1'b0, 1'b1, 13'(q * 1024), "R3 mode");
    end
    // R8: disqualified writes
    step(16'h8000, 4'hC, 1'b1, 1'b1, 13'h0, "R8 rw high");
    step(16'h8004, 4'hC, 1'b1, 1'b0, 13'h0, "R8 decode miss");
    step(16'h0000, 4'hC, 1'b1, 1'b0, 13'h0, "R8 low space");
    step(16'h8000, 4'hC, 1'b0, 1'b0, 13'h0, "R8 no strobe");
    step(16'h8100, 4'h0, 1'b0, 1'b1, 13'h0, "R8 read");
    // mixed random traffic, R9 checked every cycle
    for (int n = 0; n < 4000; n++)
      step(pick_addr($urandom), 4'($urandom), 1'($urandom % 4 != 0), 1'($urandom % 5 == 0),
           13'($urandom), "R9 random");
    // R7: reset clears state mid-run
    rst_n = 1'b0;
    step(16'h0000, 4'h0, 1'b0, 1'b1, 13'h0400, "R7 mid reset");
    step(16'h3FFF, 4'h0, 1'b0, 1'b1, 13'h1C00, "R7 mid reset");
    rst_n = 1'b1;
    step(16'h2000, 4'h0, 1'b0, 1'b1, 13'h0800, "R7 after");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule